// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block switches 64 kb/s channels between several serial time-division streams. Each stream carries one byte per channel per frame at a fixed bit rate. Every input stream is turned back into bytes, and those bytes go into a double-banked data memory. Each output channel is then serialised again from whatever input channel its connection entry names. An output channel can also send a fixed message byte in place of switched data, or leave its pad undriven for the whole slot.

For each output channel, the connection entry selects one of two delays. Minimum delay takes the newest byte available. Frame delay takes every byte from the previous complete input frame, so that channels bundled into a wideband connection leave together and stay in order. A plain register port writes and reads connection entries.

The serial streams are isochronous. Data moves on every clock, paced by the frame pulse, and there is no valid/ready handshake and no back-pressure: a slot that nobody reads is simply lost. The clock is the bit clock. The block uses one bit per clock, and each frame holds `N_CH` × 8 bits.

Top module: `tsi_switch`

## Requirements
- R1: When `fp_i` is high, the clock edge is bit 7 (MSB) of channel 0 on every input stream. The bit position restarts there, and with no pulse it wraps by itself after `N_CH`×8 clocks.
- R2: The output stream runs one clock behind the input frame. The bit on `sto_o` in the cycle after the edge that sampled input position p belongs to output position p. Output channel d occupies positions 8d..8d+7, MSB first.
- R3: In minimum-delay mode (delay bit 0), output channel d carries the current frame's byte when source channel c < d. Otherwise it carries the previous frame's byte.
- R4: In frame-delay mode (delay bit 1), every output channel carries its source byte from the previous input frame.
- R5: Any output channel may take any channel of any input stream, and several outputs may take the same source.
- R6: With the message bit set, the slot carries the entry's message byte, whatever the switched data and delay bit are.
- R7: With the enable bit clear, `sto_oe_o` is low and `sto_o` is 0 for the whole slot.
- R8: After reset, every connection entry and every stored byte is zero, so all outputs are disabled.
- R9: `cfg_we_i` writes `cfg_wdata_i` to the entry at `cfg_addr_i` = {output stream, output channel}. With the defaults, the fields are: source channel [4:0], source stream [6:5], message byte [14:7], delay bit [15], message bit [16] and enable bit [17]. The new entry is used for slots that start after the write edge.
- R10: `cfg_rdata_o` shows, one clock after an address is presented, the entry at that address as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, one clock wide, on channel 0 bit 7 |
| sti_i | input | N_STREAMS | Serial input streams |
| sto_o | output | N_STREAMS | Serial output streams |
| sto_oe_o | output | N_STREAMS | Pad drive enable per output stream, low means high-impedance |
| cfg_we_i | input | 1 | Connection entry write strobe |
| cfg_addr_i | input | log2(N_STREAMS)+log2(N_CH) | Entry address {stream, channel} |
| cfg_wdata_i | input | log2(N_STREAMS)+log2(N_CH)+11 | Entry write data |
| cfg_rdata_o | output | log2(N_STREAMS)+log2(N_CH)+11 | Entry read data, registered |

## Verification
A wrong bank choice or a wrong stored-before comparison shows up as a byte from the neighbouring frame. It appears within the first frame in which the affected slot carries fresh random data. A bit counter that slips moves every later byte by one bit, and this shows from the next slot on. A corrupted connection entry appears at its next slot, at most one frame later, or one clock after its address is read back.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {
    DLY_MIN   = 1'b0,
    DLY_FRAME = 1'b1
  } dly_e;

  // entry = {enable, message, delay, message byte, source stream, source channel}
  function automatic int entry_width(input int sw, input int chw);
    return chw + sw + 11;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int N_CH = 32,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fp_i,
  output logic [CHW-1:0] slot_o,
  output logic [2:0]     bit_o,
  output logic           bank_o
);
  localparam int POSW = CHW + 3;
  localparam logic [POSW-1:0] LAST = POSW'(N_CH * 8 - 1);

  logic [POSW-1:0] cnt_q;
  logic [POSW-1:0] pos;
  logic            bank_q;

  // R1: restart on the pulse, otherwise free-run and wrap
  always_comb begin
    if (fp_i || cnt_q == LAST) pos = '0;
    else                       pos = cnt_q + POSW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LAST;
      bank_q <= 1'b0;
    end else begin
      cnt_q <= pos;
      if (pos == '0) bank_q <= ~bank_q;
    end
  end

  assign slot_o = pos[POSW-1:3];
  assign bit_o  = pos[2:0];
  assign bank_o = bank_q ^ (pos == '0);
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int N_STREAMS = 4,
  parameter int N_CH      = 32,
  localparam int SW  = $clog2(N_STREAMS),
  localparam int CHW = $clog2(N_CH)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_STREAMS-1:0]               sti_i,
  input  logic [CHW-1:0]                     slot_i,
  input  logic [2:0]                         bit_i,
  input  logic                               bank_i,
  input  logic [N_STREAMS-1:0][SW-1:0]       rd_stream_i,
  input  logic [N_STREAMS-1:0][CHW-1:0]      rd_ch_i,
  input  logic [N_STREAMS-1:0]               rd_bank_i,
  output logic [N_STREAMS-1:0][7:0]          rd_data_o
);
  logic [6:0] sr_q  [N_STREAMS];
  logic [7:0] mem_q [2][N_STREAMS][N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STREAMS; s++) begin
        sr_q[s] <= '0;
        for (int c = 0; c < N_CH; c++) begin
          mem_q[0][s][c] <= '0;
          mem_q[1][s][c] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < N_STREAMS; s++) begin
        sr_q[s] <= {sr_q[s][5:0], sti_i[s]};
        if (bit_i == 3'd7) mem_q[bank_i][s][slot_i] <= {sr_q[s], sti_i[s]};
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N_STREAMS; o++)
      rd_data_o[o] = mem_q[rd_bank_i[o]][rd_stream_i[o]][rd_ch_i[o]];
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int N_STREAMS = 4,
  parameter int N_CH      = 32,
  localparam int SW  = $clog2(N_STREAMS),
  localparam int CHW = $clog2(N_CH),
  localparam int AW  = SW + CHW,
  localparam int EW  = tsi_pkg::entry_width(SW, CHW)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [EW-1:0]                 wdata_i,
  output logic [EW-1:0]                 rdata_o,
  input  logic [CHW-1:0]                slot_i,
  output logic [N_STREAMS-1:0][EW-1:0]  entry_o
);
  localparam int DEPTH = N_STREAMS * N_CH;

  logic [EW-1:0] ent_q [DEPTH];
  logic [EW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) ent_q[addr_i] <= wdata_i;
      rdata_q <= ent_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

  always_comb begin
    for (int o = 0; o < N_STREAMS; o++)
      entry_o[o] = ent_q[{SW'(o), slot_i}];
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
  parameter int N_STREAMS = 4,
  parameter int N_CH      = 32,
  localparam int SW  = $clog2(N_STREAMS),
  localparam int CHW = $clog2(N_CH),
  localparam int EW  = tsi_pkg::entry_width(SW, CHW)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CHW-1:0]                slot_i,
  input  logic [2:0]                    bit_i,
  input  logic                          bank_i,
  input  logic [N_STREAMS-1:0][EW-1:0]  entry_i,
  input  logic [N_STREAMS-1:0][7:0]     rd_data_i,
  output logic [N_STREAMS-1:0][SW-1:0]  rd_stream_o,
  output logic [N_STREAMS-1:0][CHW-1:0] rd_ch_o,
  output logic [N_STREAMS-1:0]          rd_bank_o,
  output logic [N_STREAMS-1:0]          sto_o,
  output logic [N_STREAMS-1:0]          sto_oe_o
);
  localparam int MSG_LO  = CHW + SW;
  localparam int DLY_BIT = MSG_LO + 8;
  localparam int MEN_BIT = DLY_BIT + 1;
  localparam int OE_BIT  = MEN_BIT + 1;

  for (genvar o = 0; o < N_STREAMS; o++) begin : g_lane
    logic [CHW-1:0]     src_ch;
    logic [SW-1:0]      src_st;
    logic [7:0]         msg;
    tsi_pkg::dly_e      dmode;
    logic               msg_en;
    logic               oe_en;
    logic               use_cur;
    logic [7:0]         fetch;
    logic [6:0]         sh_q;
    logic               bit_q;
    logic               oe_q;

    assign src_ch = entry_i[o][CHW-1:0];
    assign src_st = entry_i[o][MSG_LO-1:CHW];
    assign msg    = entry_i[o][DLY_BIT-1:MSG_LO];
    assign dmode  = tsi_pkg::dly_e'(entry_i[o][DLY_BIT]);
    assign msg_en = entry_i[o][MEN_BIT];
    assign oe_en  = entry_i[o][OE_BIT];

    // R3/R4: the source byte is in this frame's bank only if its slot has already ended
    assign use_cur = (dmode == tsi_pkg::DLY_MIN) && (src_ch < slot_i);

    assign rd_stream_o[o] = src_st;
    assign rd_ch_o[o]     = src_ch;
    assign rd_bank_o[o]   = use_cur ? bank_i : ~bank_i;

    assign fetch = msg_en ? msg : rd_data_i[o];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        bit_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (bit_i == 3'd0) begin
        oe_q  <= oe_en;
        bit_q <= oe_en & fetch[7];
        sh_q  <= fetch[6:0];
      end else begin
        bit_q <= oe_q & sh_q[6];
        sh_q  <= {sh_q[5:0], 1'b0};
      end
    end

    assign sto_o[o]    = bit_q;
    assign sto_oe_o[o] = oe_q;
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int N_STREAMS = 4,
  parameter int N_CH      = 32,
  localparam int SW  = $clog2(N_STREAMS),
  localparam int CHW = $clog2(N_CH),
  localparam int AW  = SW + CHW,
  localparam int EW  = tsi_pkg::entry_width(SW, CHW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fp_i,
  input  logic [N_STREAMS-1:0] sti_i,
  output logic [N_STREAMS-1:0] sto_o,
  output logic [N_STREAMS-1:0] sto_oe_o,
  input  logic                 cfg_we_i,
  input  logic [AW-1:0]        cfg_addr_i,
  input  logic [EW-1:0]        cfg_wdata_i,
  output logic [EW-1:0]        cfg_rdata_o
);
  logic [CHW-1:0]                slot;
  logic [2:0]                    bit_idx;
  logic                          bank;
  logic [N_STREAMS-1:0][EW-1:0]  entry;
  logic [N_STREAMS-1:0][SW-1:0]  rd_stream;
  logic [N_STREAMS-1:0][CHW-1:0] rd_ch;
  logic [N_STREAMS-1:0]          rd_bank;
  logic [N_STREAMS-1:0][7:0]     rd_data;

  tsi_timing #(.N_CH(N_CH)) u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fp_i   (fp_i),
    .slot_o (slot),
    .bit_o  (bit_idx),
    .bank_o (bank)
  );

  tsi_rx #(.N_STREAMS(N_STREAMS), .N_CH(N_CH)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sti_i       (sti_i),
    .slot_i      (slot),
    .bit_i       (bit_idx),
    .bank_i      (bank),
    .rd_stream_i (rd_stream),
    .rd_ch_i     (rd_ch),
    .rd_bank_i   (rd_bank),
    .rd_data_o   (rd_data)
  );

  tsi_cmem #(.N_STREAMS(N_STREAMS), .N_CH(N_CH)) u_cmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .slot_i  (slot),
    .entry_o (entry)
  );

  tsi_tx #(.N_STREAMS(N_STREAMS), .N_CH(N_CH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_i      (slot),
    .bit_i       (bit_idx),
    .bank_i      (bank),
    .entry_i     (entry),
    .rd_data_i   (rd_data),
    .rd_stream_o (rd_stream),
    .rd_ch_o     (rd_ch),
    .rd_bank_o   (rd_bank),
    .sto_o       (sto_o),
    .sto_oe_o    (sto_oe_o)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int N_STREAMS = 4,
  parameter int N_CH      = 32,
  localparam int SW  = $clog2(N_STREAMS),
  localparam int CHW = $clog2(N_CH),
  localparam int AW  = SW + CHW,
  localparam int EW  = tsi_pkg::entry_width(SW, CHW)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_STREAMS-1:0] sto_o,
  input logic [N_STREAMS-1:0] sto_oe_o,
  input logic                 cfg_we_i,
  input logic [AW-1:0]        cfg_addr_i,
  input logic [EW-1:0]        cfg_wdata_i,
  input logic [EW-1:0]        cfg_rdata_o,
  input logic [CHW-1:0]       slot_i,
  input logic [2:0]           bit_i
);
  localparam logic [CHW-1:0] LAST_SLOT = CHW'(N_CH - 1);

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == LAST_SLOT && bit_i == 3'd7) |=> (slot_i == '0 && bit_i == 3'd0));

  p_oe_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i != 3'd0) |=> $stable(sto_oe_o));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sto_o & ~sto_oe_o) == '0));

  p_readback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && $stable(cfg_addr_i)) |=> (cfg_rdata_o == $past(cfg_wdata_i, 2)));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(cfg_addr_i)) |=> $stable(cfg_rdata_o));
endmodule

bind tsi_switch tsi_switch_chk #(.N_STREAMS(N_STREAMS), .N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sto_o       (sto_o),
  .sto_oe_o    (sto_oe_o),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .slot_i      (slot),
  .bit_i       (bit_idx)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int NC  = 32;
  localparam int SW  = 2;
  localparam int CHW = 5;
  localparam int AW  = SW + CHW;
  localparam int EW  = CHW + SW + 11;
  localparam int FB  = NC * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp = 1'b0;
  logic we = 1'b0;
  logic [NS-1:0] sti = '0;
  logic [AW-1:0] addr = '0;
  logic [EW-1:0] wdata = '0;
  wire  [NS-1:0] sto;
  wire  [NS-1:0] sto_oe;
  wire  [EW-1:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_switch #(.N_STREAMS(NS), .N_CH(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .sti_i(sti),
    .sto_o(sto), .sto_oe_o(sto_oe),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
  );

  int total = 0;
  int bad = 0;
  int scnt = 0;
  int skip = 0;
  string phase = "R2";

  // reference model state
  logic [EW-1:0] cfg_m [NS*NC];
  logic [7:0] cur [NS][NC];
  logic [7:0] prev [NS][NC];
  logic [7:0] srm [NS];
  logic [7:0] ebyte [NS];
  logic [NS-1:0] eoe;
  logic [NS-1:0] exp_bit;
  logic [NS-1:0] exp_oe;
  string etag [NS];
  int mpos;
  bit chk_on = 0;

  function automatic logic [EW-1:0] pack(input bit oe, input bit msg, input bit cdly,
                                         input logic [7:0] mb, input int ss, input int cs);
    return {oe, msg, cdly, mb, SW'(ss), CHW'(cs)};
  endfunction

  always @(posedge clk) begin
    int b;
    int d;
    if (!rst_n) begin
      mpos = FB - 1;
      chk_on = 0;
      eoe = '0;
      for (int s = 0; s < NS; s++) begin
        srm[s] = '0; ebyte[s] = '0; etag[s] = "R8";
        for (int c = 0; c < NC; c++) begin
          cur[s][c] = '0; prev[s][c] = '0; cfg_m[s*NC+c] = '0;
        end
      end
    end else begin
      mpos = fp ? 0 : ((mpos == FB - 1) ? 0 : mpos + 1);
      b = mpos % 8;
      d = mpos / 8;
      if (mpos == 0) prev = cur;
      for (int s = 0; s < NS; s++) begin
        srm[s] = {srm[s][6:0], sti[s]};
        if (b == 7) cur[s][d] = srm[s];
      end
      for (int o = 0; o < NS; o++) begin
        if (b == 0) begin
          logic [EW-1:0] e;
          int ss, cs;
          e = cfg_m[o*NC+d];
          cs = int'(e[CHW-1:0]);
          ss = int'(e[CHW+SW-1:CHW]);
          eoe[o] = e[EW-1];
          if (!e[EW-1]) begin ebyte[o] = 8'h00; etag[o] = "R7"; end
          else if (e[EW-2]) begin ebyte[o] = e[CHW+SW+7:CHW+SW]; etag[o] = "R6"; end
          else if (e[EW-3]) begin ebyte[o] = prev[ss][cs]; etag[o] = "R4 R5"; end
          else if (cs < d) begin ebyte[o] = cur[ss][cs]; etag[o] = "R3 R5"; end
          else begin ebyte[o] = prev[ss][cs]; etag[o] = "R3 R5"; end
        end
        exp_bit[o] = eoe[o] ? ebyte[o][7-b] : 1'b0;
        exp_oe[o]  = eoe[o];
      end
      if (we) cfg_m[addr] = wdata;
      chk_on = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      for (int o = 0; o < NS; o++) begin
        total++;
        if (sto[o] !== exp_bit[o] || sto_oe[o] !== exp_oe[o]) begin
          bad++;
          $display("FAIL %s %s out%0d pos %0d: got sto=%b oe=%b expected sto=%b oe=%b",
                   phase, etag[o], o, mpos, sto[o], sto_oe[o], exp_bit[o], exp_oe[o]);
        end
      end
    end
  end

  task automatic step(input bit w, input int a, input logic [EW-1:0] dv);
    @(negedge clk);
    we = w;
    addr = AW'(a);
    wdata = dv;
    fp = (scnt == 0) && (skip == 0);
    if (scnt == 0 && skip > 0) skip--;
    sti = NS'($urandom);
    scnt = (scnt + 1) % FB;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0);
  endtask

  task automatic readback(input int a, input logic [EW-1:0] expv, input string tag);
    step(0, a, '0);
    step(0, a, '0);
    total++;
    if (rdata !== expv) begin
      bad++;
      $display("FAIL %s readback addr %0d: got %h expected %h", tag, a, rdata, expv);
    end
  endtask

  function automatic logic [EW-1:0] map_a(input int i);
    return pack(!(i % 13 == 4), (i % 11 == 5), ((i / 4) % 2) == 1,
                8'(i * 5 + 17), (i * 3 + 1) % NS, (i * 7 + 3) % NC);
  endfunction

  initial begin
    fp = 1'b1;
    repeat (4) @(negedge clk);
    scnt = 1;
    rst_n = 1'b1;
    // R8: empty entries after reset, outputs disabled (checked every cycle too)
    readback(0, '0, "R8");
    readback(37, '0, "R8");
    readback(NS*NC-1, '0, "R8");
    run(FB);
    // R9: program a mixed map while traffic flows
    phase = "R9";
    for (int i = 0; i < NS*NC; i++) step(1, i, map_a(i));
    run(FB);
    phase = "R2";
    for (int i = 0; i < NS*NC; i += 9) readback(i, map_a(i), "R10");
    run(4 * FB);
    // R1: missing frame pulses, the counter keeps time alone
    phase = "R1";
    skip = 2;
    run(3 * FB);
    // R4: grouped frame-delay channels on out0, reversed minimum-delay on out1
    phase = "R4";
    for (int k = 0; k < NC; k++) begin
      step(1, k, pack(1, 0, 1, 8'h00, 2, k));
      step(1, NC + k, pack(1, 0, 0, 8'h00, 3, NC - 1 - k));
    end
    run(4 * FB);
    readback(NC + 3, pack(1, 0, 0, 8'h00, 3, NC - 4), "R10");
    // R6 / R7: message on all of out2, out3 disabled
    phase = "R6";
    for (int k = 0; k < NC; k++) begin
      step(1, 2*NC + k, pack(1, 1, k % 2 == 1, 8'(8'hA5 ^ k), 1, k));
      step(1, 3*NC + k, pack(0, 0, 0, 8'hFF, 0, k));
    end
    run(3 * FB);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule